// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit logical address into a physical address by walking a two-level page table held in memory. The logical address is cut into three fields. The top 12 bits index a first-level table whose location comes from a base input. The middle 10 bits index the second-level table that the first-level entry points to. The low 10 bits are the byte offset inside a 1 KB page.

One translation is accepted at a time. The walker issues two dependent reads on a single-outstanding memory read port. It then reports either a physical address with a done pulse, or a fault pulse if either table entry is marked invalid. A busy output tells the requester when the walker can take a new request.

Top module: `pt_walker`

## Requirements
- R1: Out of reset the walker is idle: `busy_o`, `mem_req_o`, `done_o` and `fault_o` are low and `paddr_o` is zero. While idle it issues no read and raises no pulse.
- R2: A request sampled while idle is accepted. In the next cycle `busy_o` is high and a read is issued at address `root_base_i + 4 * vaddr_i[31:20]`.
- R3: When the first-level entry returns with bit 0 set, the second read is issued at `{entry[31:10], 10'b0} + 4 * vaddr_i[19:10]`.
- R4: When the second-level entry returns with bit 0 set, `paddr_o` becomes `{entry[31:10], vaddr_i[9:0]}` and `done_o` pulses. The offset passes through unchanged.
- R5: A first-level entry with bit 0 clear ends the walk with a `fault_o` pulse, and no second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with a `fault_o` pulse, and `paddr_o` reads zero.
- R7: At most one read is outstanding. `mem_req_o` does not rise again until `mem_valid_i` has answered the previous read.
- R8: `busy_o` stays high from acceptance until the done or fault pulse. Requests that arrive while busy are ignored and do not change the result or start a new walk.
- R9: `done_o` and `fault_o` are never high together. Each lasts exactly one cycle, and `busy_o` is low in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request |
| vaddr_i | input | 32 | Logical address to translate |
| root_base_i | input | 32 | Physical address of the first-level table |
| mem_req_o | output | 1 | Read request, one cycle per read |
| mem_addr_o | output | 32 | Read address, valid while `mem_req_o` is high |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data: bit 0 is the valid flag, bits 31:10 the base |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| fault_o | output | 1 | One-cycle pulse: an entry was invalid |
| paddr_o | output | 32 | Translated physical address |

## Verification
The bench sweeps first-level indices at both ends of the range and in the middle. It crosses them with second-level indices 0, 1, 6, 512 and 1023, and uses a different offset for each walk. The memory model marks entries invalid by simple arithmetic rules, so the same sweep reaches success, a first-level fault and a second-level fault. The read-address checks separate the two index fields, and a wrong field or a wrong shift shows up at once. Read latency varies between walks. Some walks carry an extra request in mid-walk, which separates a walker that latches its inputs from one that samples them late or restarts.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUT,
    ST_WT_OUT,
    ST_RD_IN,
    ST_WT_IN,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int AW     = 32,
  parameter int IDX_W  = 12,
  parameter int ENT_SH = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  localparam int PAD_W = AW - IDX_W;

  assign addr_o = base_i + ({{PAD_W{1'b0}}, idx_i} << ENT_SH);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        mem_valid_i,
  input  logic        entry_ok_i,
  output walk_state_e state_o,
  output logic        accept_o,
  output logic        ld_tbl_o,
  output logic        ld_pa_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_RD_OUT;
      ST_RD_OUT: state_d = ST_WT_OUT;
      ST_WT_OUT: if (mem_valid_i) state_d = entry_ok_i ? ST_RD_IN : ST_FAULT;
      ST_RD_IN:  state_d = ST_WT_IN;
      ST_WT_IN:  if (mem_valid_i) state_d = entry_ok_i ? ST_DONE : ST_FAULT;
      ST_DONE:   state_d = ST_IDLE;
      ST_FAULT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign ld_tbl_o = (state_q == ST_WT_OUT) && mem_valid_i && entry_ok_i;
  assign ld_pa_o  = (state_q == ST_WT_IN) && mem_valid_i && entry_ok_i;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OUT_W = 12,
  parameter int IN_W  = 10,
  parameter int OFF_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [VA_W-1:0] root_base_i,
  output logic            mem_req_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_valid_i,
  input  logic [VA_W-1:0] mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fault_o,
  output logic [VA_W-1:0] paddr_o
);
  localparam int OUT_LO = IN_W + OFF_W;
  localparam int IN_LO  = OFF_W;
  localparam int BASE_W = VA_W - OFF_W;

  walk_state_e state;
  logic        accept, ld_tbl, ld_pa;
  logic [VA_W-1:0] va_q, root_q, tbl_q, paddr_q;
  logic [VA_W-1:0] out_addr, in_addr;
  logic [BASE_W-1:0] ent_base;
  logic entry_ok;
  logic unused_rsvd;

  assign entry_ok    = mem_rdata_i[0];
  assign ent_base    = mem_rdata_i[VA_W-1:OFF_W];
  assign unused_rsvd = ^mem_rdata_i[OFF_W-1:1];

  ptw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mem_valid_i (mem_valid_i),
    .entry_ok_i  (entry_ok),
    .state_o     (state),
    .accept_o    (accept),
    .ld_tbl_o    (ld_tbl),
    .ld_pa_o     (ld_pa)
  );

  ptw_entry_addr #(.AW(VA_W), .IDX_W(OUT_W), .ENT_SH(2)) u_out_addr (
    .base_i (root_q),
    .idx_i  (va_q[VA_W-1:OUT_LO]),
    .addr_o (out_addr)
  );

  ptw_entry_addr #(.AW(VA_W), .IDX_W(IN_W), .ENT_SH(2)) u_in_addr (
    .base_i (tbl_q),
    .idx_i  (va_q[OUT_LO-1:IN_LO]),
    .addr_o (in_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
    end else begin
      if (accept) begin
        va_q    <= vaddr_i;
        root_q  <= root_base_i;
        paddr_q <= '0;
      end
      if (ld_tbl) tbl_q   <= {ent_base, {OFF_W{1'b0}}};
      if (ld_pa)  paddr_q <= {ent_base, va_q[OFF_W-1:0]};
    end
  end

  assign mem_req_o  = (state == ST_RD_OUT) || (state == ST_RD_IN);
  assign mem_addr_o = (state == ST_RD_IN) ? in_addr : out_addr;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);
  assign fault_o    = (state == ST_FAULT);
  assign paddr_o    = paddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic mem_req_o,
  input logic mem_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic fault_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (mem_req_o)   pend_q <= 1'b1;
    else if (mem_valid_i) pend_q <= 1'b0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o && !fault_o));

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> (busy_o && mem_req_o));

  a_r7_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);

  a_r8_busy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !fault_o) |=> busy_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_fault_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !busy_o);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .mem_req_o   (mem_req_o),
  .mem_valid_i (mem_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  localparam logic [31:0] ROOT  = 32'h0001_0000;
  localparam logic [31:0] INNER = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [31:0] root_base_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o, fault_o;
  logic [31:0] paddr_o;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int reads = 0;
  logic [31:0] addr_log [4];

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .vaddr_i(vaddr_i),
    .root_base_i(root_base_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .fault_o(fault_o), .paddr_o(paddr_o)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int unsigned i, k, j, fr;
    if (a >= ROOT && a < ROOT + 32'd16384) begin
      i = (a - ROOT) >> 2;
      return (INNER + (i << 12)) | ((i % 5 != 3) ? 32'd1 : 32'd0);
    end else if (a >= INNER && a < INNER + 32'h0100_0000) begin
      j  = a - INNER;
      i  = j >> 12;
      k  = (j >> 2) & 32'h3FF;
      fr = (i * 37 + k * 11 + 5) & 32'h3F_FFFF;
      return (fr << 10) | (((i + k) % 7 != 0) ? 32'd1 : 32'd0);
    end
    return 32'hFFFF_FFFE;
  endfunction

  // memory responder: answers each read after lat cycles
  initial forever begin
    logic [31:0] a;
    @(negedge clk);
    mem_valid_i = 1'b0;
    if (mem_req_o) begin
      a = mem_addr_o;
      if (reads < 4) addr_log[reads] = a;
      reads++;
      repeat (lat) @(negedge clk);
      mem_rdata_i = mem_word(a);
      mem_valid_i = 1'b1;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic walk(input int i, input int k, input int off, input int l, input bit inject);
    logic [31:0] va, exp_pa;
    logic d, f;
    bit ov, iv;
    int t;
    va = (32'(i) << 20) | (32'(k) << 10) | 32'(off);
    ov = (i % 5 != 3);
    iv = ((i + k) % 7 != 0);
    exp_pa = (ov && iv) ? ((((32'(i) * 37 + 32'(k) * 11 + 5) & 32'h3F_FFFF) << 10) | 32'(off)) : 32'd0;
    lat = l;
    reads = 0;
    @(negedge clk);
    req_i = 1'b1; vaddr_i = va; root_base_i = ROOT;
    @(negedge clk);
    req_i = 1'b0;
    vaddr_i = 32'hDEAD_BEEF; root_base_i = 32'h0BAD_0000;
    check(busy_o, "R2 busy after accept", 32'(busy_o), 32'd1);
    t = 0;
    while (!(done_o || fault_o) && t < 200) begin
      req_i = (inject && t == 2);
      @(negedge clk);
      t++;
    end
    req_i = 1'b0;
    d = done_o; f = fault_o;
    check(t < 200, "R8 walk ends", 32'(t), 32'd0);
    check(d == (ov && iv) && f == !(ov && iv), ov ? "R6 status" : "R5 status",
          {30'd0, d, f}, {30'd0, ov && iv, !(ov && iv)});
    check(paddr_o == exp_pa, (ov && iv) ? "R4 paddr" : "R6 paddr zero", paddr_o, exp_pa);
    check(reads == (ov ? 2 : 1), ov ? "R7 read count" : "R5 no second read", 32'(reads), ov ? 32'd2 : 32'd1);
    check(addr_log[0] == ROOT + 32'(i) * 4, "R2 outer address", addr_log[0], ROOT + 32'(i) * 4);
    if (ov)
      check(addr_log[1] == INNER + (32'(i) << 12) + 32'(k) * 4, "R3 inner address",
            addr_log[1], INNER + (32'(i) << 12) + 32'(k) * 4);
    @(negedge clk);
    check(!done_o && !fault_o && !busy_o, inject ? "R8 ignored request" : "R9 pulse and release",
          {29'd0, busy_o, done_o, fault_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ilist [6] = '{0, 1, 3, 8, 4094, 4095};
    int klist [5] = '{0, 1, 6, 512, 1023};
    int n = 0;
    repeat (3) @(negedge clk);
    check(!busy_o && !mem_req_o && !done_o && !fault_o, "R1 reset outputs",
          {28'd0, busy_o, mem_req_o, done_o, fault_o}, 32'd0);
    check(paddr_o == 32'd0, "R1 reset paddr", paddr_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !mem_req_o, "R1 idle after reset", {30'd0, busy_o, mem_req_o}, 32'd0);
    foreach (ilist[a]) begin
      foreach (klist[b]) begin
        walk(ilist[a], klist[b], (n * 97 + 3) % 1024, 1 + (n % 3), (n % 4) == 1);
        n++;
      end
    end
    walk(5, 1023, 1023, 2, 1'b1);
    walk(4095, 1023, 0, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule